// File: doc/BRIEF.md
# Six-Input External Interrupt Detector

This block turns six asynchronous interrupt pins into sticky pending flags for an interrupt controller. Each pin is set up on its own to fire on a rising edge, a falling edge, a high level or a low level. Two control bits select the mode: one picks edge or level detection, and the other picks the active sense. Each pin also has an enable bit. Software reads and clears the flags through a small word-wide register port. An enabled pin in level mode keeps asking for service until its pin goes inactive.

With the clock running, each pin passes through a two-stage synchronizer. Edge detection compares the synchronized value, already corrected for polarity, with the value held from the previous cycle. Writing the polarity register reloads that history so that a change of sense does not look like an edge. A separate wake output is built from the raw pins with gates only, so it can bring the device out of a stop state while no clock runs. The interrupt request is the OR of every flag whose enable bit is set.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, all four registers read zero, and both `irq_o` and `wake_o` are low.
- R2: The register addresses are: 0 for enables, 1 for edge select (1 = edge, 0 = level), 2 for polarity (1 = rising/high, 0 = falling/low) and 3 for flags. Bit i of every register belongs to pin i, and the enable, edge select and polarity registers read back the value last written.
- R3: In edge mode, the flag sets on the selected edge and never on the opposite edge. It becomes visible on the third rising clock edge after the pin changes, and not one edge sooner.
- R4: In level mode, the flag sets while the pin is at its active level, and it sets again at once if cleared while the pin is still held there.
- R5: A pin whose enable bit is 0 never sets its flag.
- R6: Writing 0 to a flag bit clears it, and writing 1 leaves it as it is. A trigger in the same cycle as a clear wins, so the flag stays set.
- R7: A flag set in edge mode stays set after the pin returns to its inactive state, until software clears it.
- R8: `irq_o` is high exactly when some pin has both its flag and its enable bit set. Clearing the enable bit drops `irq_o`, but the flag can still be read.
- R9: `wake_o` is a gate-only function of the raw pins. It is high whenever an enabled pin sits at the level its polarity bit marks as active, and no clock edge is needed.
- R10: In edge mode, a pulse that spans at least one rising clock edge is caught.
- R11: Writing the polarity register while a pin is held steady does not set that pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPIN | Raw external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | NPIN | Write data, one bit per pin |
| reg_rdata | output | NPIN | Read data for the register at `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Clock-free wake request |

## Verification
A pin change applied just after a falling clock edge reaches the first synchronizer stage at the next rising edge and the second stage at the edge after that. The flag is loaded at the third rising edge. The checks therefore read the flags two falling edges after the stimulus and expect nothing, then read again one falling edge later and expect the flag. A register write strobed at one falling edge takes effect at the rising edge that follows, so flag and `irq_o` results are read at the next falling edge. `wake_o` and `reg_rdata` are combinational and are sampled one nanosecond after the input or address changes, well clear of any clock edge.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int NPIN = 6,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  output logic            irq_o,
  output logic            wake_o
);

  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_EDGE = 2'd1;
  localparam logic [1:0] A_POL  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  logic [NPIN-1:0] en_q, edge_q, pol_q, flag_q, prev_q;
  logic [NPIN-1:0] sync_q [SYNC];
  logic [NPIN-1:0] s, act, trig, clr;
  logic wr_en, wr_edge, wr_pol, wr_flag;

  assign wr_en   = reg_we && (reg_addr == A_EN);
  assign wr_edge = reg_we && (reg_addr == A_EDGE);
  assign wr_pol  = reg_we && (reg_addr == A_POL);
  assign wr_flag = reg_we && (reg_addr == A_FLAG);

  assign s    = sync_q[SYNC-1];
  assign act  = ~(s ^ pol_q);
  assign trig = en_q & ((edge_q & act & ~prev_q) | (~edge_q & act));
  assign clr  = wr_flag ? ~reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata;
      if (wr_edge) edge_q <= reg_wdata;
      if (wr_pol)  pol_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else if (wr_pol) prev_q <= ~(s ^ reg_wdata);
    else prev_q <= act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= (flag_q & ~clr) | trig;
  end

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = en_q;
      A_EDGE:  reg_rdata = edge_q;
      A_POL:   reg_rdata = pol_q;
      default: reg_rdata = flag_q;
    endcase
  end

  assign irq_o  = |(flag_q & en_q);
  assign wake_o = |(en_q & ~(pin_in ^ pol_q));

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
  parameter int NPIN = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] flag,
  input logic            irq_o,
  input logic            wake_o
);

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en[i]) && !$past(flag[i])) |-> !flag[i]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && reg_addr == 2'd3 && !reg_wdata[i] && !en[i]) |-> !flag[i]);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !(reg_we && reg_addr == 2'd3 && !reg_wdata[i])) |=> flag[i]);
  end

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == '0) |-> !irq_o);
  assert_wake_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !wake_o);

endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .en(en_q), .flag(flag_q), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sim_ext_irq_detect.sv
`timescale 1ns/1ps
module sim_ext_irq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] pin_in = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic irq_o, wake_o;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ext_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_o(wake_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic setup(input logic [5:0] e, input logic [5:0] p, input logic [5:0] en,
                       input logic [5:0] pins);
    pin_in = pins; waitn(4);
    wr(2'd1, e); wr(2'd2, p); wr(2'd0, en);
    waitn(4); wr(2'd3, 6'h00);
  endtask

  task automatic t_reset();
    logic [5:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset wake", wake_o, 0);
  endtask

  task automatic t_regmap();
    logic [5:0] v;
    wr(2'd1, 6'h15); wr(2'd2, 6'h2C); wr(2'd0, 6'h00);
    rd(2'd1, v); chk("R2 edge select readback", v, 6'h15);
    rd(2'd2, v); chk("R2 polarity readback", v, 6'h2C);
    rd(2'd0, v); chk("R2 enable readback", v, 6'h00);
  endtask

  task automatic t_rise();
    logic [5:0] v;
    setup(6'h3F, 6'h3F, 6'h01, 6'h00);
    pin_in[0] = 1'b1;
    waitn(2); rd(2'd3, v); chk("R3 rising flag not yet", v, 6'h00);
    waitn(1); rd(2'd3, v); chk("R3 rising flag on third edge", v, 6'h01);
    chk("R8 irq with enabled flag", irq_o, 1);
    pin_in[0] = 1'b0; waitn(4);
    rd(2'd3, v); chk("R7 flag held after pin release", v, 6'h01);
    wr(2'd3, 6'h3E); rd(2'd3, v); chk("R6 write zero clears", v, 6'h00);
    chk("R8 irq drops with flag", irq_o, 0);
  endtask

  task automatic t_fall();
    logic [5:0] v;
    setup(6'h3F, 6'h00, 6'h02, 6'h00);
    pin_in[1] = 1'b1; waitn(4);
    rd(2'd3, v); chk("R3 rising ignored in falling mode", v, 6'h00);
    pin_in[1] = 1'b0; waitn(3);
    rd(2'd3, v); chk("R3 falling edge flag", v, 6'h02);
  endtask

  task automatic t_level_high();
    logic [5:0] v;
    setup(6'h00, 6'h04, 6'h04, 6'h00);
    pin_in[2] = 1'b1; waitn(3);
    rd(2'd3, v); chk("R4 level high flag", v, 6'h04);
    wr(2'd3, 6'h00); rd(2'd3, v); chk("R6 trigger beats clear", v, 6'h04);
    wr(2'd3, 6'h3F); rd(2'd3, v); chk("R6 write one keeps", v, 6'h04);
    pin_in[2] = 1'b0; waitn(3);
    wr(2'd3, 6'h00); rd(2'd3, v); chk("R4 clear after level released", v, 6'h00);
  endtask

  task automatic t_level_low();
    logic [5:0] v;
    setup(6'h00, 6'h00, 6'h08, 6'h08);
    rd(2'd3, v); chk("R4 inactive high in low mode", v, 6'h00);
    pin_in[3] = 1'b0; waitn(3);
    rd(2'd3, v); chk("R4 level low flag", v, 6'h08);
  endtask

  task automatic t_disabled();
    logic [5:0] v;
    setup(6'h3F, 6'h3F, 6'h00, 6'h00);
    pin_in[4] = 1'b1; #1;
    chk("R9 wake stays low when disabled", wake_o, 0);
    waitn(4); rd(2'd3, v); chk("R5 disabled pin no flag", v, 6'h00);
    chk("R5 disabled pin no irq", irq_o, 0);
  endtask

  task automatic t_pulse();
    logic [5:0] v;
    setup(6'h3F, 6'h3F, 6'h20, 6'h00);
    pin_in[5] = 1'b1; waitn(1); pin_in[5] = 1'b0; waitn(2);
    rd(2'd3, v); chk("R10 one-cycle pulse caught", v, 6'h20);
  endtask

  task automatic t_polswap();
    logic [5:0] v;
    setup(6'h3F, 6'h00, 6'h01, 6'h01);
    wr(2'd2, 6'h01); waitn(4);
    rd(2'd3, v); chk("R11 polarity write no false edge", v, 6'h00);
  endtask

  task automatic t_wake_mask();
    logic [5:0] v;
    setup(6'h00, 6'h01, 6'h01, 6'h00);
    #1; chk("R9 wake low at inactive level", wake_o, 0);
    pin_in[0] = 1'b1; #1;
    chk("R9 wake rises without clock edge", wake_o, 1);
    waitn(3); pin_in[0] = 1'b0; waitn(3);
    chk("R8 irq from level flag", irq_o, 1);
    wr(2'd0, 6'h00);
    chk("R8 irq masked by enable", irq_o, 0);
    rd(2'd3, v); chk("R8 flag still readable", v, 6'h01);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitn(3);
    t_reset();
    rst_n = 1'b1;
    waitn(2);
    t_regmap();
    t_rise();
    t_fall();
    t_level_high();
    t_level_low();
    t_disabled();
    t_pulse();
    t_polswap();
    t_wake_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule